// File: doc/BRIEF.md
# CAN Operating-Mode Sequencer

This block keeps track of which operating mode a CAN controller is in: sleep, initialization, normal or bus-off. Software drives level requests for sleep and for initialization and reads back registered acknowledge flags. Any move that depends on the bus only completes after the block has counted the required runs of recessive bits. These moves are leaving sleep and leaving bus-off. The receive line is sampled on a bit-time strobe that the surrounding controller supplies. Bit timing, frame handling and error counting stay outside the block. The transmit error count arrives as an input.

A recessive bus level is logic 1 and a dominant level is logic 0. One idle run means `RUN_LEN` (default 11) recessive samples in a row. Recovering from bus-off takes `REC_RUNS` (default 128) such runs, counted back to back. Two choices are selectable per input:
- Bus-off recovery can return to normal mode by itself, or it can wait for a software request.
- Bus activity seen during sleep can start a wake on its own, or it can only raise a wake pulse.

A loopback select makes the block sample the internal transmit line instead of the external pin.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, sleep_ack is 1, init_ack is 0, bus_off is 0 and wake_pulse is 0.
- R2: Once the sleep request is low, sleep_ack clears only after RUN_LEN consecutive recessive (1) samples. The block then reports normal mode (init_ack 0) when the init request is low.
- R3: A dominant (0) sample restarts the recessive-run count, so a run of RUN_LEN-1 ones followed by a zero does not release sleep.
- R4: An init request made while the sleep request is still high has no effect in sleep. With the sleep request low and the init request high, init_ack rises in the same cycle that sleep_ack clears, and never earlier. sleep_ack and init_ack are never both 1.
- R5: With loopback high, the sampled line is tx_line and rx_pin is ignored.
- R6: The line is sampled only in cycles where bit_tick is 1. A recessive level held without ticks does not release sleep.
- R7: In normal mode, a tec value greater than 255 sets bus_off. A value of exactly 255 does not.
- R8: With auto_busoff_en high, bus_off stays 1 after REC_RUNS-1 idle runs and clears after REC_RUNS runs. The block then returns to normal mode (init_ack 0, sleep_ack 0).
- R9: With auto_busoff_en low, an init request during recovery is ignored, and completing recovery alone does not leave bus-off. An init request after recovery completes moves the block to initialization (init_ack 1, bus_off 0).
- R10: With auto_wake_en high, a recessive-to-dominant sample edge during sleep starts the exit even though the sleep request stays high. No wake_pulse is given. sleep_ack clears after the next idle run. Sleep is not re-entered until the sleep request has been released and raised again.
- R11: With auto_wake_en low, a recessive-to-dominant sample edge in sleep gives exactly one one-cycle wake_pulse, and sleep_ack stays 1 while the sleep request is held.
- R12: In initialization, dropping the init request moves the block to normal mode. In normal mode, raising the init request gives init_ack, and raising the sleep request with init low gives sleep_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Bit-time strobe; the line is sampled when high |
| req_sleep | input | 1 | Software sleep request (level) |
| req_init | input | 1 | Software initialization request (level) |
| auto_busoff_en | input | 1 | 1: leave bus-off by itself once recovery completes |
| auto_wake_en | input | 1 | 1: bus activity in sleep starts a wake in hardware |
| loopback | input | 1 | 1: sample tx_line instead of rx_pin |
| rx_pin | input | 1 | External receive line (1 = recessive) |
| tx_line | input | 1 | Internal transmit line (1 = recessive) |
| tec | input | TEC_W | Transmit error count |
| sleep_ack | output | 1 | Sleep mode acknowledge |
| init_ack | output | 1 | Initialization mode acknowledge |
| bus_off | output | 1 | Bus-off state flag |
| wake_pulse | output | 1 | One-cycle pulse on bus activity in sleep (manual wake) |

## Verification
The idle-run counter is exercised with a directed run of ten ones cut by a zero, followed by a randomly biased bit stream. A bench model predicts the exact bit at which sleep releases, which separates a counter that restarts on a dominant sample from one that only counts ones. A loopback exit made with the pin held dominant shows which line is sampled. Recessive levels held without ticks show that samples are gated by the strobe. Bus-off is tried with error counts of 255 and 256. Recovery is stopped after one run short of the limit and again at the limit, under both automatic and software-driven return. Wake edges are applied with automatic wake on and off, which separates a hardware-started exit from a pulse-only indication.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_INIT   = 2'd1,
    MODE_NORMAL = 2'd2,
    MODE_BUSOFF = 2'd3
  } op_mode_t;
endpackage

// File: rtl/can_rx_sampler.sv
// Selects the receive source, registers one sample per bit strobe and
// flags recessive-to-dominant transitions between successive samples.
module can_rx_sampler (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic loopback,
  input  logic rx_pin,
  input  logic tx_line,
  output logic bit_stb,
  output logic bit_val,
  output logic fall_stb
);
  logic line_sel;
  assign line_sel = loopback ? tx_line : rx_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_stb  <= 1'b0;
      bit_val  <= 1'b1;
      fall_stb <= 1'b0;
    end else begin
      bit_stb  <= bit_tick;
      fall_stb <= bit_tick & bit_val & ~line_sel;
      if (bit_tick) bit_val <= line_sel;
    end
  end

  // A reported edge means the stored sample just went from 1 to 0.
  assert_fall_edge_R11: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> ($past(bit_val) && !bit_val));

  // Without a strobe the stored sample holds.
  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |-> $stable(bit_val));
endmodule

// File: rtl/can_idle_run.sv
// Counts consecutive recessive samples; emits a pulse per completed run
// and restarts, so back-to-back runs are counted separately.
module can_idle_run #(
  parameter int RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_stb,
  input  logic bit_val,
  output logic run_pulse
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q     <= '0;
      run_pulse <= 1'b0;
    end else begin
      run_pulse <= 1'b0;
      if (bit_stb) begin
        if (!bit_val) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q     <= '0;
          run_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_run_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(RUN_LEN));

  assert_dominant_no_run_R3: assert property (@(posedge clk) disable iff (rst)
    (en && bit_stb && !bit_val) |=> !run_pulse);
endmodule

// File: rtl/can_recovery_count.sv
// Counts completed idle runs while in bus-off; saturates at the target.
module can_recovery_count #(
  parameter int REC_RUNS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic run_pulse,
  output logic rec_done
);
  localparam int RC = $clog2(REC_RUNS + 1);
  localparam logic [RC-1:0] TARGET = RC'(REC_RUNS);

  logic [RC-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
    end else if (run_pulse && cnt_q != TARGET) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rec_done = (cnt_q == TARGET);

  assert_rec_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TARGET);
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RUN_LEN      = 11,
  parameter int REC_RUNS     = 128,
  parameter int TEC_W        = 9,
  parameter int BUSOFF_LIMIT = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             req_sleep,
  input  logic             req_init,
  input  logic             auto_busoff_en,
  input  logic             auto_wake_en,
  input  logic             loopback,
  input  logic             rx_pin,
  input  logic             tx_line,
  input  logic [TEC_W-1:0] tec,
  output logic             sleep_ack,
  output logic             init_ack,
  output logic             bus_off,
  output logic             wake_pulse
);
  localparam logic [TEC_W-1:0] TEC_LIMIT = TEC_W'(BUSOFF_LIMIT);

  op_mode_t mode_q, mode_n;
  logic     woke_q, woke_n;
  logic     blocked_q, blocked_n;
  logic     wake_n;
  logic     bit_stb, bit_val, fall_stb;
  logic     run_pulse, rec_done;
  logic     leaving_sleep, run_en, rec_en;

  can_rx_sampler u_smp (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .loopback (loopback),
    .rx_pin   (rx_pin),
    .tx_line  (tx_line),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .fall_stb (fall_stb)
  );

  assign leaving_sleep = (mode_q == MODE_SLEEP) && (!req_sleep || woke_q);
  assign rec_en        = (mode_q == MODE_BUSOFF);
  assign run_en        = leaving_sleep || rec_en;

  can_idle_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst       (rst),
    .en        (run_en),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .run_pulse (run_pulse)
  );

  can_recovery_count #(.REC_RUNS(REC_RUNS)) u_rec (
    .clk       (clk),
    .rst       (rst),
    .en        (rec_en),
    .run_pulse (run_pulse),
    .rec_done  (rec_done)
  );

  always_comb begin
    mode_n    = mode_q;
    woke_n    = woke_q;
    blocked_n = blocked_q & req_sleep;
    case (mode_q)
      MODE_SLEEP: begin
        if (fall_stb && auto_wake_en) woke_n = 1'b1;
        if (leaving_sleep && run_pulse) begin
          mode_n    = req_init ? MODE_INIT : MODE_NORMAL;
          woke_n    = 1'b0;
          blocked_n = woke_q & req_sleep;
        end
      end
      MODE_INIT: begin
        if (req_sleep && !req_init && !blocked_q) mode_n = MODE_SLEEP;
        else if (!req_init)                       mode_n = MODE_NORMAL;
      end
      MODE_NORMAL: begin
        if (tec > TEC_LIMIT)                  mode_n = MODE_BUSOFF;
        else if (req_init)                    mode_n = MODE_INIT;
        else if (req_sleep && !blocked_q)     mode_n = MODE_SLEEP;
      end
      default: begin
        if (rec_done) begin
          if (auto_busoff_en) mode_n = MODE_NORMAL;
          else if (req_init)  mode_n = MODE_INIT;
        end
      end
    endcase
    wake_n = fall_stb && !auto_wake_en &&
             (mode_q == MODE_SLEEP) && (mode_n == MODE_SLEEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_SLEEP;
      woke_q     <= 1'b0;
      blocked_q  <= 1'b0;
      sleep_ack  <= 1'b1;
      init_ack   <= 1'b0;
      bus_off    <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      woke_q     <= woke_n;
      blocked_q  <= blocked_n;
      sleep_ack  <= (mode_n == MODE_SLEEP);
      init_ack   <= (mode_n == MODE_INIT);
      bus_off    <= (mode_n == MODE_BUSOFF);
      wake_pulse <= wake_n;
    end
  end

  assert_ack_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(sleep_ack && init_ack));

  assert_sleep_exit_run_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_ack) |-> $past(run_pulse));

  assert_busoff_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NORMAL && tec > TEC_LIMIT) |=> bus_off);

  assert_busoff_exit_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_off) |-> $past(rec_done));

  assert_wake_in_sleep_R11: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> sleep_ack);
endmodule

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LEN    = 11;
  localparam int REC_RUNS   = 128;
  localparam int TEC_W      = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0;
  logic req_sleep = 1'b1;
  logic req_init = 1'b0;
  logic auto_busoff_en = 1'b0;
  logic auto_wake_en = 1'b0;
  logic loopback = 1'b0;
  logic rx_pin = 1'b1;
  logic tx_line = 1'b1;
  logic [TEC_W-1:0] tec = '0;
  logic sleep_ack, init_ack, bus_off, wake_pulse;

  int total = 0;
  int bad = 0;
  int wake_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_seq #(.RUN_LEN(RUN_LEN), .REC_RUNS(REC_RUNS), .TEC_W(TEC_W)) uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .req_sleep(req_sleep),
    .req_init(req_init), .auto_busoff_en(auto_busoff_en),
    .auto_wake_en(auto_wake_en), .loopback(loopback), .rx_pin(rx_pin),
    .tx_line(tx_line), .tec(tec), .sleep_ack(sleep_ack), .init_ack(init_ack),
    .bus_off(bus_off), .wake_pulse(wake_pulse)
  );

  always @(negedge clk) if (!rst && wake_pulse) wake_cnt++;

  function automatic int next_run(input int run, input logic b);
    return b ? run + 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic pin_v, input logic tx_v);
    @(negedge clk);
    rx_pin = pin_v; tx_line = tx_v; bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send(1'b1, 1'b1);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int run;
    int w0;
    logic b;
    void'($urandom(32'd7351));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(2);
    // R1 reset state
    check("R1 sleep_ack", sleep_ack, 1);
    check("R1 init_ack", init_ack, 0);
    check("R1 bus_off", bus_off, 0);
    check("R1 wake_pulse", wake_pulse, 0);

    // R4 init request with sleep held: no effect
    req_init = 1'b1;
    send_ones(RUN_LEN + 1);
    check("R4 sleep held sleep_ack", sleep_ack, 1);
    check("R4 sleep held init_ack", init_ack, 0);

    // R6 no ticks: recessive level alone does nothing
    req_sleep = 1'b0;
    rx_pin = 1'b1;
    settle(60);
    check("R6 no tick sleep_ack", sleep_ack, 1);

    // R3/R2/R4 directed prefix then random stream, model-predicted exit
    run = 0;
    for (int i = 0; i < RUN_LEN - 1; i++) begin
      send(1'b1, 1'b1); run = next_run(run, 1'b1);
    end
    send(1'b0, 1'b0); run = next_run(run, 1'b0);
    check("R3 after break sleep_ack", sleep_ack, 1);
    for (int i = 0; i < 400 && run < RUN_LEN; i++) begin
      b = (($urandom % 6) != 0);
      send(b, b);
      run = next_run(run, b);
      check("R3 stream sleep_ack", sleep_ack, (run >= RUN_LEN) ? 0 : 1);
      check("R4 stream init_ack", init_ack, (run >= RUN_LEN) ? 1 : 0);
    end
    check("R2 exited", sleep_ack, 0);

    // R12 init -> normal -> init -> normal -> sleep
    req_init = 1'b0; settle(3);
    check("R12 normal init_ack", init_ack, 0);
    check("R12 normal sleep_ack", sleep_ack, 0);
    req_init = 1'b1; settle(3);
    check("R12 init_ack", init_ack, 1);
    req_init = 1'b0; settle(3);
    req_sleep = 1'b1; settle(3);
    check("R12 sleep_ack", sleep_ack, 1);

    // R5 loopback: pin dominant, internal line recessive
    loopback = 1'b1; req_sleep = 1'b0;
    for (int i = 0; i < RUN_LEN - 1; i++) send(1'b0, 1'b1);
    check("R5 one short sleep_ack", sleep_ack, 1);
    send(1'b0, 1'b1);
    check("R5 loopback exit sleep_ack", sleep_ack, 0);
    check("R2 exit to normal init_ack", init_ack, 0);
    loopback = 1'b0; rx_pin = 1'b1; tx_line = 1'b1;

    // R7 error threshold
    auto_busoff_en = 1'b1;
    tec = 9'd255; settle(4);
    check("R7 tec 255 bus_off", bus_off, 0);
    tec = 9'd256; settle(3);
    check("R7 tec 256 bus_off", bus_off, 1);
    tec = '0;

    // R8 automatic recovery
    send(1'b0, 1'b0);
    send_ones(RUN_LEN * (REC_RUNS - 1));
    check("R8 one run short bus_off", bus_off, 1);
    send_ones(RUN_LEN);
    check("R8 recovered bus_off", bus_off, 0);
    check("R8 recovered init_ack", init_ack, 0);
    check("R8 recovered sleep_ack", sleep_ack, 0);

    // R9 software-driven recovery
    auto_busoff_en = 1'b0;
    tec = 9'd300; settle(3);
    check("R9 entered bus_off", bus_off, 1);
    tec = '0;
    req_init = 1'b1; settle(3);
    check("R9 early request bus_off", bus_off, 1);
    check("R9 early request init_ack", init_ack, 0);
    req_init = 1'b0;
    send_ones(RUN_LEN * REC_RUNS);
    check("R9 done without request bus_off", bus_off, 1);
    req_init = 1'b1; settle(3);
    check("R9 request after done bus_off", bus_off, 0);
    check("R9 request after done init_ack", init_ack, 1);
    req_init = 1'b0; settle(3);

    // R11 manual wake
    req_sleep = 1'b1; settle(3);
    check("R11 asleep", sleep_ack, 1);
    w0 = wake_cnt;
    send(1'b1, 1'b1);
    send(1'b0, 1'b0);
    check("R11 one wake pulse", wake_cnt - w0, 1);
    check("R11 still asleep", sleep_ack, 1);
    send_ones(RUN_LEN + 2);
    check("R11 held asleep", sleep_ack, 1);

    // R10 automatic wake
    auto_wake_en = 1'b1;
    w0 = wake_cnt;
    send(1'b0, 1'b0);
    check("R10 no wake pulse", wake_cnt - w0, 0);
    check("R10 before run sleep_ack", sleep_ack, 1);
    send_ones(RUN_LEN);
    check("R10 woke sleep_ack", sleep_ack, 0);
    check("R10 woke init_ack", init_ack, 0);
    settle(20);
    check("R10 no re-entry sleep_ack", sleep_ack, 0);
    req_sleep = 1'b0; settle(3);
    req_sleep = 1'b1; settle(3);
    check("R10 re-entry sleep_ack", sleep_ack, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule